// File: doc/BRIEF.md
# Byte-Buffered I2C Target Port

This block is a 7-bit-addressed I2C target for a microcontroller-style peripheral bus. It takes the raw SCL and SDA levels from the pads and passes them through a two-flop synchronizer. From these it finds START and STOP conditions and compares the first byte of each transfer with a programmable own address. It drives open-drain pull-down enables for both bus lines.

One byte-wide buffer register carries data in both directions. A status register shows the state of that buffer and of the transaction, and a single-cycle interrupt marks each byte boundary. Received bytes are acknowledged only if the CPU has emptied the buffer. In the read direction the block holds SCL low after every byte until the CPU has placed a fresh byte in the buffer and asked for the clock to be let go. The direction flag is taken from the address byte alone and stays unchanged until the next address or STOP.

The CPU reaches two registers. With `cpu_sel`=0 it reaches the data buffer. With `cpu_sel`=1 a read returns status and a write issues control strobes.

Top module: `i2c_tgt`

## Requirements
- R1: The first 8 bits after a START, MSB first, are taken as address bits 6..0 followed by a direction bit. When bits 7..1 equal `own_addr`, the block pulls SDA low during the ninth clock, pulses `irq` and clears status bit1 (data flag). On a mismatch it does not acknowledge, does not interrupt and ignores all traffic until the next START.
- R2: Status bit2 (read flag) is loaded from bit 0 of a matching address byte (1 = master reads). Acknowledge bits and data bytes later in the transaction never change it.
- R3: A data byte received while status bit0 (full) is clear is acknowledged and stored in the buffer. It sets full and the data flag, and `irq` pulses.
- R4: The full flag is cleared only by a CPU read of the buffer (`cpu_rd` with `cpu_sel`=0). A status read leaves it set.
- R5: A data byte received while full is set is not acknowledged and the buffer keeps its old value. Status bit3 (overflow) is set and `irq` still pulses. Writing a 1 to control bit3 clears overflow.
- R6: After the acknowledge of a read address, `scl_oe` stays high. Writing 1 to control bit0 (release) lets SCL go only if the buffer was written since the last byte started out; otherwise the write is ignored.
- R7: A transmitted byte goes out MSB first. While the clock is held and a fresh byte is loaded, `sda_oe` already equals the inverse of that byte's bit 7.
- R8: When the master acknowledges a transmitted byte, `irq` pulses and SCL is held again. A fresh load plus release is then needed for the next byte.
- R9: When the master does not acknowledge a transmitted byte, both enables drop. No interrupt is raised and the clock is not held again, even if the master goes on clocking.
- R10: A STOP clears the read flag and the data flag. A repeated START begins a new address phase with a fresh read flag.
- R11: `sda_oe` changes only while the synchronized SCL is low.
- R12: Status layout: bit0 full, bit1 data, bit2 read, bit3 overflow, bit4 clock held, bit5 buffer loaded. After reset both enables, `irq` and the whole status byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Target address to answer |
| scl_i | input | 1 | SCL level at the pad |
| sda_i | input | 1 | SDA level at the pad |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_sel | input | 1 | 0 selects the buffer, 1 selects status and control |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational on `cpu_sel` |
| irq | output | 1 | One-cycle pulse at each byte boundary |

## Verification
A bus edge takes two clocks to pass through the synchronizer. The registered enables, flags and `irq` then follow on the third rising clock edge after the pad changes. CPU read data is combinational, and a CPU write takes effect at the next edge. The bench's bus model holds each SCL phase for ten clocks and reads status only after a byte has completed and SCL has been low for several clocks. Interrupt pulses are tallied continuously, so each count is compared only after all pulses of a byte are certain to have happened.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_RX,
    ST_ACK_R,
    ST_HOLD,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } tgt_state_t;

  // status bit positions
  localparam int unsigned SB_FULL   = 0;
  localparam int unsigned SB_DATA   = 1;
  localparam int unsigned SB_READ   = 2;
  localparam int unsigned SB_OVF    = 3;
  localparam int unsigned SB_HOLD   = 4;
  localparam int unsigned SB_LOADED = 5;

  // control strobe bit positions
  localparam int unsigned CB_RELEASE = 0;
  localparam int unsigned CB_OVF_CLR = 3;

  localparam logic SEL_BUF = 1'b0;
  localparam logic SEL_CSR = 1'b1;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0]  raw;
  logic [STAGES-1:0] chain [LINES];
  logic [LINES-1:0]  last_q;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[l] <= '1;
      else        chain[l] <= {chain[l][STAGES-2:0], raw[l]};
    end
  end

  assign scl_s = chain[0][STAGES-1];
  assign sda_s = chain[1][STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '1;
    else        last_q <= {sda_s, scl_s};
  end

  assign scl_rise  =  scl_s & ~last_q[0];
  assign scl_fall  = ~scl_s &  last_q[0];
  assign start_det =  scl_s &  last_q[0] & ~sda_s &  last_q[1];
  assign stop_det  =  scl_s &  last_q[0] &  sda_s & ~last_q[1];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              buf_full,
  input  logic              loaded,
  input  logic [BYTE_W-1:0] buf_q,
  input  logic              tx_take,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic              in_hold,
  output logic              ev_clr,
  output logic              ev_addr,
  output logic              ev_rx,
  output logic              ev_ovf,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  tgt_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              sda_q, sda_d;
  logic              scl_q, scl_d;
  logic              mack_q, mack_d;
  logic              irq_q, irq_d;
  logic              byte_done;

  assign byte_done = (cnt_q == CNT_W'(BYTE_W));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    sda_d   = sda_q;
    scl_d   = scl_q;
    mack_d  = mack_q;
    irq_d   = 1'b0;
    ev_clr  = 1'b0;
    ev_addr = 1'b0;
    ev_rx   = 1'b0;
    ev_ovf  = 1'b0;
    if (stop_det || start_det) begin
      st_d   = start_det ? ST_ADDR : ST_IDLE;
      cnt_d  = '0;
      sda_d  = 1'b0;
      scl_d  = 1'b0;
      mack_d = 1'b0;
      ev_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && !byte_done) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && byte_done) begin
            cnt_d = '0;
            if (st_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == own_addr) begin
                ev_addr = 1'b1;
                irq_d   = 1'b1;
                sda_d   = 1'b1;
                st_d    = ST_ACK_A;
              end else begin
                st_d = ST_SKIP;
              end
            end else begin
              irq_d = 1'b1;
              st_d  = ST_ACK_R;
              if (buf_full) begin
                ev_ovf = 1'b1;
              end else begin
                ev_rx = 1'b1;
                sda_d = 1'b1;
              end
            end
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            sda_d = 1'b0;
            if (sh_q[0]) begin
              st_d  = ST_HOLD;
              scl_d = 1'b1;
            end else begin
              st_d = ST_RX;
            end
          end
        end
        ST_ACK_R: begin
          if (scl_fall) begin
            sda_d = 1'b0;
            st_d  = ST_RX;
          end
        end
        ST_HOLD: begin
          if (tx_take) begin
            tx_d  = buf_q;
            scl_d = 1'b0;
            sda_d = ~buf_q[BYTE_W-1];
            cnt_d = '0;
            st_d  = ST_TX;
          end else begin
            sda_d = loaded & ~buf_q[BYTE_W-1];
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              st_d  = ST_TX_ACK;
              sda_d = 1'b0;
              cnt_d = '0;
            end else begin
              tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
              sda_d = ~tx_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
            irq_d  = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d  = ST_HOLD;
              scl_d = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      sda_q  <= 1'b0;
      scl_q  <= 1'b0;
      mack_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      sda_q  <= sda_d;
      scl_q  <= scl_d;
      mack_q <= mack_d;
      irq_q  <= irq_d;
    end
  end

  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;
  assign irq     = irq_q;
  assign in_hold = (st_q == ST_HOLD);
  assign rx_byte = sh_q;

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              cpu_sel,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  input  logic              ev_clr,
  input  logic              ev_addr,
  input  logic              ev_rx,
  input  logic              ev_ovf,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              in_hold,
  output logic [BYTE_W-1:0] buf_q,
  output logic              loaded_q,
  output logic              full_q,
  output logic              data_q,
  output logic              read_q,
  output logic              ovf_q,
  output logic              tx_take
);

  logic [BYTE_W-1:0] buf_d, csr;
  logic loaded_d, full_d, data_d, read_d, ovf_d;
  logic wr_buf, rd_buf, wr_csr, rel_req;

  assign wr_buf  = cpu_wr & (cpu_sel == SEL_BUF);
  assign rd_buf  = cpu_rd & (cpu_sel == SEL_BUF);
  assign wr_csr  = cpu_wr & (cpu_sel == SEL_CSR);
  assign rel_req = wr_csr & cpu_wdata[CB_RELEASE];
  assign tx_take = in_hold & rel_req & loaded_q;

  always_comb begin
    buf_d    = buf_q;
    loaded_d = loaded_q;
    full_d   = full_q;
    data_d   = data_q;
    read_d   = read_q;
    ovf_d    = ovf_q;
    if (ev_rx)       buf_d = rx_byte;
    else if (wr_buf) buf_d = cpu_wdata;
    if (tx_take)     loaded_d = 1'b0;
    else if (wr_buf) loaded_d = 1'b1;
    if (ev_rx)       full_d = 1'b1;
    else if (rd_buf) full_d = 1'b0;
    if (ev_clr) begin
      data_d = 1'b0;
      read_d = 1'b0;
    end else if (ev_addr) begin
      data_d = 1'b0;
      read_d = rx_byte[0];
    end else if (ev_rx || ev_ovf) begin
      data_d = 1'b1;
    end
    if (ev_ovf)                               ovf_d = 1'b1;
    else if (wr_csr && cpu_wdata[CB_OVF_CLR]) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      loaded_q <= 1'b0;
      full_q   <= 1'b0;
      data_q   <= 1'b0;
      read_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      buf_q    <= buf_d;
      loaded_q <= loaded_d;
      full_q   <= full_d;
      data_q   <= data_d;
      read_q   <= read_d;
      ovf_q    <= ovf_d;
    end
  end

  always_comb begin
    csr            = '0;
    csr[SB_FULL]   = full_q;
    csr[SB_DATA]   = data_q;
    csr[SB_READ]   = read_q;
    csr[SB_OVF]    = ovf_q;
    csr[SB_HOLD]   = in_hold;
    csr[SB_LOADED] = loaded_q;
  end

  assign cpu_rdata = (cpu_sel == SEL_CSR) ? csr : buf_q;

endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              cpu_sel,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata,
  output logic              irq
);

  logic [1:0] rst_pipe;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic full_f, data_f, read_f, ovf_f, loaded_f, in_hold, tx_take;
  logic ev_clr, ev_addr, ev_rx, ev_ovf;
  logic [BYTE_W-1:0] buf_q, rx_byte;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rst_int), .own_addr(own_addr), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .buf_full(full_f), .loaded(loaded_f), .buf_q(buf_q),
    .tx_take(tx_take), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .in_hold(in_hold), .ev_clr(ev_clr), .ev_addr(ev_addr), .ev_rx(ev_rx),
    .ev_ovf(ev_ovf), .rx_byte(rx_byte)
  );

  i2c_tgt_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_int), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ev_clr(ev_clr), .ev_addr(ev_addr), .ev_rx(ev_rx), .ev_ovf(ev_ovf),
    .rx_byte(rx_byte), .in_hold(in_hold), .buf_q(buf_q), .loaded_q(loaded_f),
    .full_q(full_f), .data_q(data_f), .read_q(read_f), .ovf_q(ovf_f),
    .tx_take(tx_take)
  );

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic cpu_rd,
  input logic cpu_sel,
  input logic full_f,
  input logic data_f,
  input logic read_f,
  input logic ovf_f,
  input logic loaded_f
);

  // R11: data line enable moves only while the clock is low
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R2: read flag frozen during the data phase
  p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_f && $past(data_f)) |-> $stable(read_f));

  // R3: interrupt lasts a single cycle
  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6: clock released only with a loaded byte, or by START/STOP
  p_release_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && !$past(start_det || stop_det)) |-> $past(loaded_f));

  // R4: full flag drops only after a CPU buffer read
  p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_f) |-> $past(cpu_rd && !cpu_sel));

  // R5: overflowed byte is not acknowledged
  p_ovf_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_f) |-> !sda_oe);

endmodule

bind i2c_tgt i2c_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_int), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .full_f(full_f), .data_f(data_f),
  .read_f(read_f), .ovf_f(ovf_f), .loaded_f(loaded_f)
);

// File: tb/test_i2c_tgt.sv
`timescale 1ns/1ps
module test_i2c_tgt;

  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h2B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  int n_chk = 0, n_bad = 0, irq_cnt = 0, exp_irq = 0, r11_bad = 0;
  logic sda_oe_d = 1'b0;
  bit done = 1'b0;

  i2c_tgt i_i2c_tgt (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (irq === 1'b1) irq_cnt <= irq_cnt + 1;
    sda_oe_d <= sda_oe;
    if (rst_n && (sda_oe !== sda_oe_d) && scl_bus) r11_bad <= r11_bad + 1;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up;
    m_scl = 1'b1;
    for (int g = 0; g < 4000 && scl_bus !== 1'b1; g++) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); scl_up; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); scl_up; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bit(logic b);
    m_sda = b; tick(Q); scl_up; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q); scl_up; tick(Q); b = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
  endtask

  task automatic cpu_read(logic sel, output logic [7:0] d);
    cpu_sel = sel; cpu_rd = !sel; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic cpu_write(logic sel, logic [7:0] d);
    cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary;
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d, st;
    tick(5); rst_n = 1'b1; tick(5);
    // R12 reset state
    cpu_read(1'b1, st);
    chk("R12 reset status", st, 8'h00);
    chk("R12 reset enables", {6'b0, scl_oe, sda_oe}, 8'h00);
    chk("R12 reset irq", 8'(irq_cnt), 8'h00);

    // R1 sweep of every single-bit address mismatch
    for (int k = 0; k < 7; k++) begin
      bus_start;
      put_byte({OWN ^ 7'(1 << k), 1'b0}, ack);
      chk("R1 mismatch nack", {7'b0, ack}, 8'h01);
      put_byte(8'h00, ack);
      chk("R1 ignored data nack", {7'b0, ack}, 8'h01);
      bus_stop;
    end
    chk("R1 no irq on mismatch", 8'(irq_cnt), 8'(exp_irq));

    // R3/R4 write sweep
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11) ^ (i << 5));
      bus_start;
      put_byte({OWN, 1'b0}, ack); exp_irq++;
      chk("R1 match ack", {7'b0, ack}, 8'h00);
      cpu_read(1'b1, st);
      chk("R1 address status", st, 8'h00);
      put_byte(v, ack); exp_irq++;
      chk("R3 data ack", {7'b0, ack}, 8'h00);
      cpu_read(1'b1, st);
      chk("R3 full and data flags", st, 8'h03);
      cpu_read(1'b1, st);
      chk("R4 status read keeps full", st, 8'h03);
      cpu_read(1'b0, d);
      chk("R3 buffer value", d, v);
      cpu_read(1'b1, st);
      chk("R4 buffer read clears full", st, 8'h02);
      chk("R3 irq count", 8'(irq_cnt), 8'(exp_irq));
      bus_stop;
      tick(4);
      cpu_read(1'b1, st);
      chk("R10 stop clears flags", st, 8'h00);
    end

    // R5 overflow
    bus_start;
    put_byte({OWN, 1'b0}, ack); exp_irq++;
    put_byte(8'h5C, ack); exp_irq++;
    put_byte(8'hC3, ack); exp_irq++;
    chk("R5 overflow nack", {7'b0, ack}, 8'h01);
    cpu_read(1'b1, st);
    chk("R5 overflow status", st, 8'h0B);
    chk("R5 overflow irq", 8'(irq_cnt), 8'(exp_irq));
    cpu_write(1'b1, 8'h08);
    cpu_read(1'b1, st);
    chk("R5 overflow clear", st, 8'h03);
    cpu_read(1'b0, d);
    chk("R5 buffer kept", d, 8'h5C);
    bus_stop;

    // R6/R7/R8/R9 read transaction
    bus_start;
    put_byte({OWN, 1'b1}, ack); exp_irq++;
    chk("R1 read address ack", {7'b0, ack}, 8'h00);
    tick(5);
    chk("R6 clock held", {7'b0, scl_oe}, 8'h01);
    cpu_read(1'b1, st);
    chk("R2 read flag set", st, 8'h14);
    cpu_write(1'b1, 8'h01); tick(8);
    chk("R6 release without load ignored", {7'b0, scl_oe}, 8'h01);
    cpu_write(1'b0, 8'h35); tick(4);
    chk("R7 msb zero drives sda", {7'b0, sda_oe}, 8'h01);
    cpu_read(1'b1, st);
    chk("R12 loaded and held", st, 8'h34);
    cpu_write(1'b1, 8'h01); tick(4);
    chk("R6 clock released", {7'b0, scl_oe}, 8'h00);
    get_byte(d);
    chk("R7 first byte", d, 8'h35);
    put_bit(1'b0); exp_irq++;
    tick(4);
    chk("R8 held again", {7'b0, scl_oe}, 8'h01);
    chk("R8 irq on master ack", 8'(irq_cnt), 8'(exp_irq));
    cpu_read(1'b1, st);
    chk("R2 read flag kept after ack", st, 8'h14);
    cpu_write(1'b1, 8'h01); tick(8);
    chk("R8 release needs fresh load", {7'b0, scl_oe}, 8'h01);
    cpu_write(1'b0, 8'hA6); tick(4);
    chk("R7 msb one leaves sda", {7'b0, sda_oe}, 8'h00);
    cpu_write(1'b1, 8'h01);
    get_byte(d);
    chk("R7 second byte", d, 8'hA6);
    put_bit(1'b1);
    tick(4);
    chk("R9 lines free after nack", {6'b0, scl_oe, sda_oe}, 8'h00);
    cpu_read(1'b1, st);
    chk("R9 no hold after nack", st, 8'h04);
    get_byte(d);
    chk("R9 extra clocks undriven", d, 8'hFF);
    chk("R9 no irq after nack", 8'(irq_cnt), 8'(exp_irq));
    bus_stop; tick(4);
    cpu_read(1'b1, st);
    chk("R10 stop clears read flag", st, 8'h00);

    // R10 repeated start
    bus_start;
    put_byte({OWN, 1'b0}, ack); exp_irq++;
    put_byte(8'h3C, ack); exp_irq++;
    chk("R3 data ack before restart", {7'b0, ack}, 8'h00);
    bus_start;
    put_byte({OWN, 1'b1}, ack); exp_irq++;
    chk("R10 restart address ack", {7'b0, ack}, 8'h00);
    tick(4);
    cpu_read(1'b1, st);
    chk("R10 restart status", st, 8'h15);
    cpu_read(1'b0, d);
    chk("R10 buffer before restart", d, 8'h3C);
    cpu_write(1'b0, 8'hFF);
    cpu_write(1'b1, 8'h01);
    get_byte(d);
    chk("R7 restart byte", d, 8'hFF);
    put_bit(1'b1);
    bus_stop; tick(4);
    chk("R10 irq count", 8'(irq_cnt), 8'(exp_irq));

    chk("R11 sda stable with scl high", 8'(r11_bad), 8'h00);
    done = 1'b1;
    summary;
    $finish;
  end

endmodule